// File: doc/BRIEF.md
# Translation Fault Sequencer

This block steers a single virtual-to-physical address translation from the moment it is accepted to the moment a result is reported. When the relocation enable that applies to the access (the instruction-side enable for fetches, the data-side enable for loads and stores) is clear, the address passes through unchanged with read/write permission. Otherwise the block asks the block-translation unit first. Only when that unit misses does it start the page-table walker. A grant of zero from either unit, or a walk that finds no entry, ends as a fault.

A fault is reported in one of two styles, chosen by a configuration input that is sampled when the request is accepted. The software-reload style reports a miss vector, a strobe for the instruction-miss or data-miss address register, and a request to set the temporary-register state bit. The storage-interrupt style reports an instruction or data storage vector; for data accesses it also reports a data-address register strobe and a fault-status word. A quiet request never raises a fault: it reports failure only.

Each request is a transaction. It opens with a one-cycle start pulse and closes with a one-cycle done pulse, and every result output is valid in the done cycle. Taking the fault into the core is left to the surrounding logic.

Top module: `xlat_fault_seq`

## Requirements
- R1: A request whose applicable relocation enable is 0 (ms_irelo for fetches, ms_drelo for data) completes with paddr equal to the virtual address and grant 2 (read/write). Neither sub-unit is queried.
- R2: A block-translation hit with a nonzero grant completes with the block unit's address and grant, and walk_req is never raised.
- R3: A block-translation hit with grant 0 raises a protection fault (the fault-status protect bit in storage-interrupt style), and walk_req is never raised.
- R4: A block-translation miss raises walk_req exactly once. A walk that ends with match=1 and a nonzero grant completes with the walker's address and grant.
- R5: Every failed translation completes with grant 0 (none). If req_quiet was set at acceptance, exc_valid and all register strobes stay low in the done cycle.
- R6: Software-reload style (cfg_swreload=1): the vector is 0x10 for a fetch, 0x11 for a data read and 0x12 for a data write. imiss_we (fetch) or dmiss_we (data) pulses together with tgpr_set, and fault_addr carries the virtual address.
- R7: Storage-interrupt style, data fault: the vector is 0x03, and dar_we and fsr_we pulse. fault_status has bit0 = no entry found, bit1 = protection (an entry matched), bit2 = store access.
- R8: Storage-interrupt style, fetch fault: the vector is 0x04, and dar_we and fsr_we stay low.
- R9: req_start is ignored while a transaction is open. Each accepted request gives exactly one done pulse.
- R10: Latency is fixed. blk_req is high in the one cycle after acceptance. done follows acceptance by 1 cycle for a bypass, and by 3 cycles when the block unit decides.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_start | input | 1 | Start pulse for a new request |
| req_vaddr | input | AW | Virtual address |
| req_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| req_write | input | 1 | Data write |
| req_quiet | input | 1 | Report failure without a fault |
| cfg_swreload | input | 1 | 1 = software-reload fault style, 0 = storage-interrupt style |
| ms_irelo | input | 1 | Instruction relocation enable |
| ms_drelo | input | 1 | Data relocation enable |
| blk_req | output | 1 | Block-translation query; the result is sampled in this cycle |
| blk_hit | input | 1 | Block-translation hit |
| blk_grant | input | 2 | Block grant (0 none, 1 read-only, 2 read/write) |
| blk_paddr | input | AW | Block-translated address |
| walk_req | output | 1 | Start pulse for the page-table walker |
| walk_done | input | 1 | Walker finished |
| walk_match | input | 1 | Walker found a matching entry |
| walk_grant | input | 2 | Walker grant |
| walk_paddr | input | AW | Walker-translated address |
| done | output | 1 | Transaction complete |
| paddr | output | AW | Physical address |
| grant | output | 2 | Final grant code |
| exc_valid | output | 1 | Fault raised |
| exc_vector | output | 8 | Fault vector code |
| imiss_we | output | 1 | Instruction-miss address register write |
| dmiss_we | output | 1 | Data-miss address register write |
| dar_we | output | 1 | Data-address register write |
| fsr_we | output | 1 | Fault-status register write |
| fault_status | output | 3 | Fault-status value |
| fault_addr | output | AW | Address for the miss or data-address register |
| tgpr_set | output | 1 | Request to set the temporary-register state bit |

## Verification
Several properties are checked by assertions on every cycle. A bypass completes one cycle after acceptance with the input address and read/write grant. A block-unit decision never starts the walker, and the walker is started for a single cycle only. A raised fault always carries grant none. Status strobes never conflict, and the status word carries exactly one cause. Other behaviour can only be shown by the bench's scenarios: the exact vector for each access kind in each style, the fault-status bits from protection versus missing entries, quiet suppression, ignoring a start pulse while busy, and the end-to-end latencies including the walk.

// File: rtl/xfs_pkg.sv
package xfs_pkg;
  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_BLK   = 3'd1,
    S_BCHK  = 3'd2,
    S_WREQ  = 3'd3,
    S_WWAIT = 3'd4
  } xfs_state_e;

  localparam int GW = 2;
  localparam int VW = 8;
  localparam int FSW = 3;

  localparam logic [GW-1:0] GR_NONE = 2'd0;
  localparam logic [GW-1:0] GR_RO   = 2'd1;
  localparam logic [GW-1:0] GR_RW   = 2'd2;

  localparam logic [VW-1:0] VEC_DSTOR  = 8'h03;
  localparam logic [VW-1:0] VEC_ISTOR  = 8'h04;
  localparam logic [VW-1:0] VEC_IMISS  = 8'h10;
  localparam logic [VW-1:0] VEC_DRMISS = 8'h11;
  localparam logic [VW-1:0] VEC_DWMISS = 8'h12;

  localparam int FS_NOTFOUND = 0;
  localparam int FS_PROTECT  = 1;
  localparam int FS_STORE    = 2;

  typedef struct packed {
    logic fetch;
    logic write;
    logic quiet;
    logic swstyle;
  } xfs_req_t;
endpackage

// File: rtl/xfs_ctrl.sv
module xfs_ctrl
  import xfs_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_start,
  input  logic [AW-1:0]       req_vaddr,
  input  logic                req_fetch,
  input  logic                req_write,
  input  logic                req_quiet,
  input  logic                cfg_swreload,
  input  logic                ms_irelo,
  input  logic                ms_drelo,
  input  logic                blk_hit,
  input  logic [GW-1:0]       blk_grant,
  input  logic [AW-1:0]       blk_paddr,
  input  logic                walk_done,
  input  logic                walk_match,
  input  logic [GW-1:0]       walk_grant,
  input  logic [AW-1:0]       walk_paddr,
  output logic                blk_req,
  output logic                walk_req,
  output logic                idle,
  output logic                fin,
  output logic                fin_fault,
  output logic                fin_matched,
  output logic [GW-1:0]       fin_grant,
  output logic [AW-1:0]       fin_paddr,
  output xfs_req_t            cur_req,
  output logic [AW-1:0]       cur_vaddr
);
  xfs_state_e st_q, st_d;
  xfs_req_t   req_q;
  logic [AW-1:0] vaddr_q;
  logic          bhit_q;
  logic [GW-1:0] bgrant_q;
  logic [AW-1:0] bpaddr_q;
  logic          accept;
  logic          bypass_now;
  logic          cap_blk_en;

  assign bypass_now = req_fetch ? !ms_irelo : !ms_drelo;
  assign cap_blk_en = (st_q == S_BLK);

  always_comb begin
    st_d        = st_q;
    accept      = 1'b0;
    fin         = 1'b0;
    fin_fault   = 1'b0;
    fin_matched = 1'b0;
    fin_grant   = GR_NONE;
    fin_paddr   = '0;
    case (st_q)
      S_IDLE: begin
        if (req_start) begin
          accept = 1'b1;
          if (bypass_now) begin
            fin       = 1'b1;
            fin_grant = GR_RW;
            fin_paddr = req_vaddr;
          end else begin
            st_d = S_BLK;
          end
        end
      end
      S_BLK: st_d = S_BCHK;
      S_BCHK: begin
        if (bhit_q) begin
          fin  = 1'b1;
          st_d = S_IDLE;
          if (bgrant_q != GR_NONE) begin
            fin_grant = bgrant_q;
            fin_paddr = bpaddr_q;
          end else begin
            fin_fault   = 1'b1;
            fin_matched = 1'b1;
          end
        end else begin
          st_d = S_WREQ;
        end
      end
      S_WREQ: st_d = S_WWAIT;
      S_WWAIT: begin
        if (walk_done) begin
          fin  = 1'b1;
          st_d = S_IDLE;
          if (walk_match && (walk_grant != GR_NONE)) begin
            fin_grant = walk_grant;
            fin_paddr = walk_paddr;
          end else begin
            fin_fault   = 1'b1;
            fin_matched = walk_match;
          end
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q   <= '0;
      vaddr_q <= '0;
    end else if (accept) begin
      req_q.fetch   <= req_fetch;
      req_q.write   <= req_write;
      req_q.quiet   <= req_quiet;
      req_q.swstyle <= cfg_swreload;
      vaddr_q       <= req_vaddr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bhit_q   <= 1'b0;
      bgrant_q <= GR_NONE;
      bpaddr_q <= '0;
    end else if (cap_blk_en) begin
      bhit_q   <= blk_hit;
      bgrant_q <= blk_grant;
      bpaddr_q <= blk_paddr;
    end
  end

  assign blk_req   = (st_q == S_BLK);
  assign walk_req  = (st_q == S_WREQ);
  assign idle      = (st_q == S_IDLE);
  assign cur_req   = req_q;
  assign cur_vaddr = vaddr_q;

  // R2 / R3: once the block unit has hit, the walker is never started
  a_r2_no_walk_on_block_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_BCHK && bhit_q) |=> (!walk_req && st_q == S_IDLE));

  // R4: the walker start is a single-cycle pulse
  a_r4_walk_single: assert property (@(posedge clk) disable iff (!rst_n)
    walk_req |=> !walk_req);

  // R10: a translated request queries the block unit in the very next cycle
  a_r10_blk_next: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && req_start && !bypass_now) |=> blk_req);

  // R9: no acceptance while busy: a start outside idle does not reopen the block query
  a_r9_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && !blk_req && st_q != S_BCHK && req_start) |=> !blk_req);
endmodule

// File: rtl/xfs_fault_enc.sv
module xfs_fault_enc
  import xfs_pkg::*;
(
  input  logic            fault,
  input  logic            matched,
  input  xfs_req_t        req,
  output logic            exc,
  output logic [VW-1:0]   vector,
  output logic            imiss_we,
  output logic            dmiss_we,
  output logic            dar_we,
  output logic            fsr_we,
  output logic            tgpr_set,
  output logic [FSW-1:0]  fsr
);
  logic raise;

  assign raise = fault && !req.quiet;

  always_comb begin
    exc      = raise;
    vector   = '0;
    imiss_we = 1'b0;
    dmiss_we = 1'b0;
    dar_we   = 1'b0;
    fsr_we   = 1'b0;
    tgpr_set = 1'b0;
    fsr      = '0;
    if (raise) begin
      if (req.swstyle) begin
        tgpr_set = 1'b1;
        if (req.fetch) begin
          vector   = VEC_IMISS;
          imiss_we = 1'b1;
        end else begin
          vector   = req.write ? VEC_DWMISS : VEC_DRMISS;
          dmiss_we = 1'b1;
        end
      end else if (req.fetch) begin
        vector = VEC_ISTOR;
      end else begin
        vector                = VEC_DSTOR;
        dar_we                = 1'b1;
        fsr_we                = 1'b1;
        fsr[FS_NOTFOUND]      = !matched;
        fsr[FS_PROTECT]       = matched;
        fsr[FS_STORE]         = req.write;
      end
    end
  end
endmodule

// File: rtl/xfs_result.sv
module xfs_result
  import xfs_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fin,
  input  logic [GW-1:0]   fin_grant,
  input  logic [AW-1:0]   fin_paddr,
  input  logic [AW-1:0]   fin_vaddr,
  input  logic            enc_exc,
  input  logic [VW-1:0]   enc_vector,
  input  logic            enc_imiss,
  input  logic            enc_dmiss,
  input  logic            enc_dar,
  input  logic            enc_fsr,
  input  logic            enc_tgpr,
  input  logic [FSW-1:0]  enc_status,
  output logic            done,
  output logic [AW-1:0]   paddr,
  output logic [GW-1:0]   grant,
  output logic            exc_valid,
  output logic [VW-1:0]   exc_vector,
  output logic            imiss_we,
  output logic            dmiss_we,
  output logic            dar_we,
  output logic            fsr_we,
  output logic [FSW-1:0]  fault_status,
  output logic [AW-1:0]   fault_addr,
  output logic            tgpr_set
);
  logic [5:0] pulse_d;

  assign pulse_d = fin ? {enc_exc, enc_imiss, enc_dmiss, enc_dar, enc_fsr, enc_tgpr} : 6'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done      <= 1'b0;
      exc_valid <= 1'b0;
      imiss_we  <= 1'b0;
      dmiss_we  <= 1'b0;
      dar_we    <= 1'b0;
      fsr_we    <= 1'b0;
      tgpr_set  <= 1'b0;
    end else begin
      done <= fin;
      {exc_valid, imiss_we, dmiss_we, dar_we, fsr_we, tgpr_set} <= pulse_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      paddr        <= '0;
      grant        <= GR_NONE;
      exc_vector   <= '0;
      fault_status <= '0;
      fault_addr   <= '0;
    end else if (fin) begin
      paddr        <= fin_paddr;
      grant        <= fin_grant;
      exc_vector   <= enc_vector;
      fault_status <= enc_status;
      fault_addr   <= fin_vaddr;
    end
  end
endmodule

// File: rtl/xlat_fault_seq.sv
module xlat_fault_seq
  import xfs_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_start,
  input  logic [AW-1:0]   req_vaddr,
  input  logic            req_fetch,
  input  logic            req_write,
  input  logic            req_quiet,
  input  logic            cfg_swreload,
  input  logic            ms_irelo,
  input  logic            ms_drelo,
  output logic            blk_req,
  input  logic            blk_hit,
  input  logic [1:0]      blk_grant,
  input  logic [AW-1:0]   blk_paddr,
  output logic            walk_req,
  input  logic            walk_done,
  input  logic            walk_match,
  input  logic [1:0]      walk_grant,
  input  logic [AW-1:0]   walk_paddr,
  output logic            done,
  output logic [AW-1:0]   paddr,
  output logic [1:0]      grant,
  output logic            exc_valid,
  output logic [7:0]      exc_vector,
  output logic            imiss_we,
  output logic            dmiss_we,
  output logic            dar_we,
  output logic            fsr_we,
  output logic [2:0]      fault_status,
  output logic [AW-1:0]   fault_addr,
  output logic            tgpr_set
);
  logic            idle;
  logic            fin, fin_fault, fin_matched;
  logic [GW-1:0]   fin_grant;
  logic [AW-1:0]   fin_paddr;
  xfs_req_t        cur_req;
  logic [AW-1:0]   cur_vaddr;
  logic            e_exc, e_imiss, e_dmiss, e_dar, e_fsr, e_tgpr;
  logic [VW-1:0]   e_vec;
  logic [FSW-1:0]  e_status;

  xfs_ctrl #(.AW(AW)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_start(req_start), .req_vaddr(req_vaddr), .req_fetch(req_fetch),
    .req_write(req_write), .req_quiet(req_quiet), .cfg_swreload(cfg_swreload),
    .ms_irelo(ms_irelo), .ms_drelo(ms_drelo),
    .blk_hit(blk_hit), .blk_grant(blk_grant), .blk_paddr(blk_paddr),
    .walk_done(walk_done), .walk_match(walk_match), .walk_grant(walk_grant),
    .walk_paddr(walk_paddr),
    .blk_req(blk_req), .walk_req(walk_req), .idle(idle),
    .fin(fin), .fin_fault(fin_fault), .fin_matched(fin_matched),
    .fin_grant(fin_grant), .fin_paddr(fin_paddr),
    .cur_req(cur_req), .cur_vaddr(cur_vaddr)
  );

  xfs_fault_enc u_enc (
    .fault(fin_fault), .matched(fin_matched), .req(cur_req),
    .exc(e_exc), .vector(e_vec), .imiss_we(e_imiss), .dmiss_we(e_dmiss),
    .dar_we(e_dar), .fsr_we(e_fsr), .tgpr_set(e_tgpr), .fsr(e_status)
  );

  xfs_result #(.AW(AW)) u_res (
    .clk(clk), .rst_n(rst_n), .fin(fin), .fin_grant(fin_grant),
    .fin_paddr(fin_paddr), .fin_vaddr(cur_vaddr),
    .enc_exc(e_exc), .enc_vector(e_vec), .enc_imiss(e_imiss),
    .enc_dmiss(e_dmiss), .enc_dar(e_dar), .enc_fsr(e_fsr),
    .enc_tgpr(e_tgpr), .enc_status(e_status),
    .done(done), .paddr(paddr), .grant(grant), .exc_valid(exc_valid),
    .exc_vector(exc_vector), .imiss_we(imiss_we), .dmiss_we(dmiss_we),
    .dar_we(dar_we), .fsr_we(fsr_we), .fault_status(fault_status),
    .fault_addr(fault_addr), .tgpr_set(tgpr_set)
  );

  // R1 / R10: bypass completes one cycle later with the input address, read/write
  a_r1_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && req_start && (req_fetch ? !ms_irelo : !ms_drelo))
      |=> (done && grant == GR_RW && paddr == $past(req_vaddr) && !exc_valid));

  // R5: a raised fault always reports grant none in the done cycle
  a_r5_fault_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> (done && grant == GR_NONE));

  // R6: the temporary-register request comes with exactly one miss-register strobe
  a_r6_tgpr_with_miss: assert property (@(posedge clk) disable iff (!rst_n)
    tgpr_set |-> ((imiss_we ^ dmiss_we) && !dar_we && !fsr_we));

  // R7: a status update names exactly one cause and comes with the address update
  a_r7_one_cause: assert property (@(posedge clk) disable iff (!rst_n)
    fsr_we |-> ($countones(fault_status[1:0]) == 1 && dar_we && exc_valid));

  // R8: register strobes never overlap across the two styles
  a_r8_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({imiss_we, dmiss_we, dar_we}));
endmodule

// File: tb/xlat_fault_seq_bench.sv
module xlat_fault_seq_bench;
  localparam int AW = 32;

  typedef struct {
    string       tag;
    logic [31:0] paddr;
    logic [1:0]  grant;
    logic        exc;
    logic [7:0]  vec;
    logic        imiss, dmiss, dar, fsrw, tgpr;
    logic [2:0]  fsr;
    logic [31:0] faddr;
    int          blks, walks, lat;
    int          blk0, walk0, cyc0;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n;
  logic req_start, req_fetch, req_write, req_quiet, cfg_swreload, ms_irelo, ms_drelo;
  logic [AW-1:0] req_vaddr, blk_paddr, walk_paddr, paddr, fault_addr;
  logic blk_req, blk_hit, walk_req, walk_done, walk_match;
  logic [1:0] blk_grant, walk_grant, grant;
  logic done, exc_valid, imiss_we, dmiss_we, dar_we, fsr_we, tgpr_set;
  logic [7:0] exc_vector;
  logic [2:0] fault_status;

  int checks = 0, fails = 0, cyc = 0, blk_cnt = 0, walk_cnt = 0, wtimer = 0;
  exp_t q[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  xlat_fault_seq #(.AW(AW)) u_xlat_fault_seq (.*);

  // walker and block-unit request counters; walker answers two cycles after its start
  always @(negedge clk) begin
    walk_done = 1'b0;
    if (wtimer > 0) begin
      wtimer = wtimer - 1;
      if (wtimer == 0) walk_done = 1'b1;
    end
    if (walk_req) begin
      walk_cnt = walk_cnt + 1;
      wtimer = 2;
    end
    if (blk_req) blk_cnt = blk_cnt + 1;
  end

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // monitor: pops one expected item per done pulse
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (q.size() == 0) begin
        chk("R9", "unexpected done", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(e.tag, "grant", {30'd0, grant}, {30'd0, e.grant});
        if (e.grant != 2'd0) chk(e.tag, "paddr", paddr, e.paddr);
        chk(e.tag, "exc_valid", {31'd0, exc_valid}, {31'd0, e.exc});
        if (e.exc) begin
          chk(e.tag, "vector", {24'd0, exc_vector}, {24'd0, e.vec});
          chk(e.tag, "fault_addr", fault_addr, e.faddr);
        end
        chk(e.tag, "strobes", {27'd0, imiss_we, dmiss_we, dar_we, fsr_we, tgpr_set},
            {27'd0, e.imiss, e.dmiss, e.dar, e.fsrw, e.tgpr});
        if (e.fsrw) chk(e.tag, "fault_status", {29'd0, fault_status}, {29'd0, e.fsr});
        chk(e.tag, "block queries", blk_cnt - e.blk0, e.blks);
        chk(e.tag, "walker starts", walk_cnt - e.walk0, e.walks);
        chk({e.tag, "/R10"}, "latency", cyc - e.cyc0, e.lat);
      end
    end
  end

  task automatic run(string tag, logic [31:0] va, logic f, logic w, logic qt, logic sw,
                     logic ir, logic dr, logic bh, logic [1:0] bg, logic [31:0] bp,
                     logic wm, logic [1:0] wg, logic [31:0] wp, logic poke);
    exp_t e;
    logic byp, fault, matched;
    @(negedge clk);
    e.tag = tag; e.exc = 0; e.vec = 0; e.imiss = 0; e.dmiss = 0; e.dar = 0;
    e.fsrw = 0; e.tgpr = 0; e.fsr = 0; e.faddr = va; e.paddr = 0; e.grant = 0;
    e.blks = 0; e.walks = 0; e.blk0 = blk_cnt; e.walk0 = walk_cnt; e.cyc0 = cyc;
    byp = f ? !ir : !dr;
    fault = 0; matched = 0;
    if (byp) begin
      e.paddr = va; e.grant = 2'd2; e.lat = 1;
    end else begin
      e.blks = 1;
      if (bh) begin
        e.lat = 3;
        if (bg != 0) begin e.paddr = bp; e.grant = bg; end
        else begin fault = 1; matched = 1; end
      end else begin
        e.walks = 1; e.lat = 6;
        if (wm && wg != 0) begin e.paddr = wp; e.grant = wg; end
        else begin fault = 1; matched = wm; end
      end
    end
    if (fault && !qt) begin
      e.exc = 1;
      if (sw) begin
        e.tgpr = 1;
        if (f) begin e.vec = 8'h10; e.imiss = 1; end
        else begin e.vec = w ? 8'h12 : 8'h11; e.dmiss = 1; end
      end else if (f) begin
        e.vec = 8'h04;
      end else begin
        e.vec = 8'h03; e.dar = 1; e.fsrw = 1; e.fsr = {w, matched, !matched};
      end
    end
    q.push_back(e);
    req_vaddr = va; req_fetch = f; req_write = w; req_quiet = qt; cfg_swreload = sw;
    ms_irelo = ir; ms_drelo = dr; blk_hit = bh; blk_grant = bg; blk_paddr = bp;
    walk_match = wm; walk_grant = wg; walk_paddr = wp; req_start = 1'b1;
    @(negedge clk);
    req_start = 1'b0;
    if (poke) begin
      // R9: second start while busy, would be a bypass if accepted
      req_vaddr = 32'hDEAD_0000; ms_drelo = 1'b0; ms_irelo = 1'b0; req_start = 1'b1;
      @(negedge clk);
      req_start = 1'b0;
    end
    for (int i = 0; i < 20 && q.size() != 0; i++) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(tag, "pending results", q.size(), 0);
  endtask

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_start = 0; req_vaddr = 0; req_fetch = 0; req_write = 0;
    req_quiet = 0; cfg_swreload = 0; ms_irelo = 0; ms_drelo = 0; blk_hit = 0;
    blk_grant = 0; blk_paddr = 0; walk_match = 0; walk_grant = 0; walk_paddr = 0;
    walk_done = 0;
    repeat (3) @(negedge clk);
    chk("reset", "outputs", {26'd0, done, exc_valid, grant, blk_req, walk_req}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1 fetch bypass (data relocation on is irrelevant)
    run("R1", 32'h1234_5678, 1, 0, 0, 0, 0, 1, 1, 2'd1, 32'h0, 0, 0, 0, 0);
    // R1 data bypass, write
    run("R1", 32'hCAFE_0004, 0, 1, 0, 1, 1, 0, 1, 2'd0, 32'h0, 0, 0, 0, 0);
    // R2 data block hit RW (instruction relocation off must not matter)
    run("R2", 32'h8000_1000, 0, 1, 0, 0, 0, 1, 1, 2'd2, 32'h0010_1000, 1, 2, 32'h5, 0);
    // R2 fetch block hit read-only
    run("R2", 32'h4000_0040, 1, 0, 0, 1, 1, 1, 1, 2'd1, 32'h0200_0040, 0, 0, 0, 0);
    // R3 / R7 block denied, data write, storage style: protect + store
    run("R3", 32'h7000_0010, 0, 1, 0, 0, 1, 1, 1, 2'd0, 32'h0, 0, 0, 0, 0);
    // R3 / R6 block denied, fetch, software style
    run("R3", 32'h7000_0020, 1, 0, 0, 1, 1, 1, 1, 2'd0, 32'h0, 0, 0, 0, 0);
    // R4 walk match RW data read
    run("R4", 32'h0123_4000, 0, 0, 0, 0, 1, 1, 0, 2'd0, 32'h0, 1, 2'd2, 32'h00AB_4000, 0);
    // R4 walk match read-only fetch
    run("R4", 32'h0222_0000, 1, 0, 0, 0, 1, 1, 0, 2'd0, 32'h0, 1, 2'd1, 32'h0033_0000, 0);
    // R7 walk miss data read: not found
    run("R7", 32'h0FF0_0100, 0, 0, 0, 0, 1, 1, 0, 2'd0, 32'h0, 0, 2'd2, 32'h0, 0);
    // R7 walk protection on data write: protect + store
    run("R7", 32'h0FF0_0200, 0, 1, 0, 0, 1, 1, 0, 2'd0, 32'h0, 1, 2'd0, 32'h0, 0);
    // R7 walk miss data write: not found + store
    run("R7", 32'h0FF0_0300, 0, 1, 0, 0, 1, 1, 0, 2'd0, 32'h0, 0, 2'd0, 32'h0, 0);
    // R8 fetch walk miss, storage style
    run("R8", 32'h0ABC_0000, 1, 0, 0, 0, 1, 1, 0, 2'd0, 32'h0, 0, 2'd0, 32'h0, 0);
    // R6 data read miss, data write miss, fetch miss, software style
    run("R6", 32'h1111_2000, 0, 0, 0, 1, 1, 1, 0, 2'd0, 32'h0, 0, 2'd0, 32'h0, 0);
    run("R6", 32'h1111_3000, 0, 1, 0, 1, 1, 1, 0, 2'd0, 32'h0, 1, 2'd0, 32'h0, 0);
    run("R6", 32'h1111_4000, 1, 0, 0, 1, 1, 1, 0, 2'd0, 32'h0, 0, 2'd0, 32'h0, 0);
    // R5 quiet failures in both styles
    run("R5", 32'h2222_0000, 0, 1, 1, 0, 1, 1, 0, 2'd0, 32'h0, 0, 2'd0, 32'h0, 0);
    run("R5", 32'h2222_1000, 1, 0, 1, 1, 1, 1, 1, 2'd0, 32'h0, 0, 2'd0, 32'h0, 0);
    // R9 start pulse while busy is ignored (block and walk paths)
    run("R9", 32'h3333_0000, 0, 0, 0, 0, 1, 1, 1, 2'd2, 32'h0044_0000, 0, 0, 0, 1);
    run("R9", 32'h3333_1000, 0, 0, 0, 0, 1, 1, 0, 2'd0, 32'h0, 1, 2'd2, 32'h0055_1000, 1);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule